// File: doc/BRIEF.md
# Signed 32-by-16 Iterative Divider

This block divides a signed 32-bit dividend by a signed 16-bit divisor and returns a 16-bit quotient, a 16-bit remainder, four condition flags (negative, zero, overflow, carry) and a trap pulse. The dividend comes from an even/odd register pair. The high word is the even register and the low word is the odd one. The register index is supplied with the operands so the block can reject an odd index. The register file and operand fetch are outside the block.

A one-cycle `start_i` pulse captures the operands. In the next cycle the block sorts out three special cases: an odd register index, a zero divisor, and the most negative dividend divided by minus one. Each of these finishes at once. All other operands go through a restoring division on magnitudes, one quotient bit per cycle. A sign fix-up stage then checks for overflow and issues write enables for the register pair. `done_o` pulses once per accepted start. The quotient, remainder and flags stay on their outputs until a later operation updates them.

Top module: `sdiv32_unit`

## Requirements
- R1: The dividend is {dvd_hi_i, dvd_lo_i} in two's complement. On success the quotient is truncated toward zero, appears on quot_o and is written to the even register (wr_even_o high for one cycle with done_o). The remainder appears on rem_o and is written to the odd register (wr_odd_o high in the same cycle).
- R2: On success the remainder carries the sign of the dividend, or is zero.
- R3: An odd index (reg_idx_i bit 0 = 1) pulses trap_o with done_o one cycle after the start edge. It takes precedence over every other case, performs no write, and leaves quot_o, rem_o and the flags unchanged.
- R4: A zero divisor on an even index gives N=0, Z=1, V=1, C=1 with done_o one cycle after the start edge, and no write.
- R5: Dividend 0x80000000 with divisor 0xFFFF gives V=1 and N=Z=C=0 with done_o one cycle after the start edge, and no write.
- R6: A signed quotient outside -32768..32767 gives V=1, N equal to the quotient's sign, Z=0 and C=0, and no write. quot_o and rem_o keep their previous values.
- R7: On success N is set for a negative quotient, Z is set for a zero quotient, and V and C are cleared.
- R8: A full division raises done_o 34 clock edges after the accepting edge. busy_o is high from the accepting edge until the edge that raises done_o. done_o lasts one cycle. After reset all outputs are zero.
- R9: A start_i pulse while busy_o is high is ignored: it produces no extra done_o, and the running result uses the first operands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, accepted when idle |
| reg_idx_i | input | 3 | Register index of the dividend pair |
| dvd_hi_i | input | 16 | Dividend high word (even register) |
| dvd_lo_i | input | 16 | Dividend low word (odd register) |
| dvs_i | input | 16 | Signed divisor |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| trap_o | output | 1 | Reserved-instruction trap, with done_o |
| wb_base_o | output | 3 | Even register index to write |
| wr_even_o | output | 1 | Write quotient to even register |
| wr_odd_o | output | 1 | Write remainder to odd register |
| quot_o | output | 16 | Quotient |
| rem_o | output | 16 | Remainder |
| flag_n_o | output | 1 | Negative flag |
| flag_z_o | output | 1 | Zero flag |
| flag_v_o | output | 1 | Overflow flag |
| flag_c_o | output | 1 | Carry flag |

## Verification
Assertions watch properties that hold on every cycle:
- a trap never comes with a write;
- an overflow or divide-by-zero completion never writes;
- a write always comes with clear V and C;
- done_o is a single-cycle pulse;
- the partial remainder always stays below the divisor;
- a start while busy leaves the captured operands unchanged.

The scoreboard scenarios are the only check on arithmetic correctness. They cover each sign combination, the ±32767/-32768 quotient boundaries, overflow in both directions, trap precedence over a zero divisor, and the exact completion latency of fast and full paths.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_CHK, ST_DIV, ST_FIX} sdiv_st_e;
  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } sdiv_flags_t;
endpackage

// File: rtl/sdiv_precheck.sv
module sdiv_precheck #(
  parameter int DVD_W = 32,
  parameter int DVS_W = 16
) (
  input  logic [DVD_W-1:0] dvd_i,
  input  logic [DVS_W-1:0] dvs_i,
  input  logic             idx_odd_i,
  output logic             is_trap_o,
  output logic             is_zero_o,
  output logic             is_maxneg_o,
  output logic             dvd_neg_o,
  output logic             dvs_neg_o,
  output logic [DVD_W-1:0] dvd_mag_o,
  output logic [DVS_W-1:0] dvs_mag_o
);
  localparam logic [DVD_W-1:0] DVD_MIN = {1'b1, {(DVD_W-1){1'b0}}};

  assign dvd_neg_o   = dvd_i[DVD_W-1];
  assign dvs_neg_o   = dvs_i[DVS_W-1];
  assign dvd_mag_o   = dvd_neg_o ? (DVD_W'(0) - dvd_i) : dvd_i;
  assign dvs_mag_o   = dvs_neg_o ? (DVS_W'(0) - dvs_i) : dvs_i;
  assign is_trap_o   = idx_odd_i;
  assign is_zero_o   = (dvs_i == '0);
  assign is_maxneg_o = (dvd_i == DVD_MIN) && (&dvs_i);
endmodule

// File: rtl/sdiv_core.sv
module sdiv_core #(
  parameter int DVD_W = 32,
  parameter int DVS_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [DVD_W-1:0] dvd_mag_i,
  input  logic [DVS_W-1:0] dvs_mag_i,
  output logic [DVD_W-1:0] quo_mag_o,
  output logic [DVS_W-1:0] rem_mag_o,
  output logic             last_o
);
  localparam int CNT_W = $clog2(DVD_W);

  logic [DVS_W-1:0] acc_q, dvs_q;
  logic [DVD_W-1:0] quo_q;
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;
  logic [DVS_W:0]   shifted, trial;
  logic             ge;

  // restoring step: shift in next dividend bit, subtract if it fits
  assign shifted = {acc_q, quo_q[DVD_W-1]};
  assign ge      = shifted >= {1'b0, dvs_q};
  assign trial   = shifted - {1'b0, dvs_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      dvs_q   <= '0;
      quo_q   <= '0;
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (load_i) begin
      acc_q   <= '0;
      dvs_q   <= dvs_mag_i;
      quo_q   <= dvd_mag_i;
      cnt_q   <= '0;
      armed_q <= 1'b1;
    end else if (step_i) begin
      acc_q <= ge ? trial[DVS_W-1:0] : shifted[DVS_W-1:0];
      quo_q <= {quo_q[DVD_W-2:0], ge};
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign quo_mag_o = quo_q;
  assign rem_mag_o = acc_q;
  assign last_o    = step_i && (cnt_q == CNT_W'(DVD_W-1));

  // R1
  rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed_q |-> (acc_q < dvs_q));
endmodule

// File: rtl/sdiv_fixup.sv
module sdiv_fixup import sdiv_pkg::*; #(
  parameter int DVD_W = 32,
  parameter int DVS_W = 16
) (
  input  logic [DVD_W-1:0] quo_mag_i,
  input  logic [DVS_W-1:0] rem_mag_i,
  input  logic             dvd_neg_i,
  input  logic             dvs_neg_i,
  output logic [DVS_W-1:0] quot_o,
  output logic [DVS_W-1:0] rem_o,
  output logic             ovf_o,
  output sdiv_flags_t      flags_o
);
  localparam logic [DVD_W-1:0] POS_LIM = {{(DVD_W-DVS_W+1){1'b0}}, {(DVS_W-1){1'b1}}};
  localparam logic [DVD_W-1:0] NEG_LIM = POS_LIM + DVD_W'(1);

  logic neg_q, mag_zero;

  assign neg_q    = dvd_neg_i ^ dvs_neg_i;
  assign mag_zero = (quo_mag_i == '0);
  assign ovf_o    = neg_q ? (quo_mag_i > NEG_LIM) : (quo_mag_i > POS_LIM);
  assign quot_o   = neg_q ? (DVS_W'(0) - quo_mag_i[DVS_W-1:0]) : quo_mag_i[DVS_W-1:0];
  assign rem_o    = dvd_neg_i ? (DVS_W'(0) - rem_mag_i) : rem_mag_i;

  always_comb begin
    flags_o.n = neg_q && !mag_zero;
    flags_o.z = !ovf_o && mag_zero;
    flags_o.v = ovf_o;
    flags_o.c = 1'b0;
  end
endmodule

// File: rtl/sdiv32_unit.sv
module sdiv32_unit import sdiv_pkg::*; #(
  parameter int DVD_W = 32,
  parameter int DVS_W = 16,
  parameter int REG_W = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [REG_W-1:0]   reg_idx_i,
  input  logic [DVD_W/2-1:0] dvd_hi_i,
  input  logic [DVD_W/2-1:0] dvd_lo_i,
  input  logic [DVS_W-1:0]   dvs_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               trap_o,
  output logic [REG_W-1:0]   wb_base_o,
  output logic               wr_even_o,
  output logic               wr_odd_o,
  output logic [DVS_W-1:0]   quot_o,
  output logic [DVS_W-1:0]   rem_o,
  output logic               flag_n_o,
  output logic               flag_z_o,
  output logic               flag_v_o,
  output logic               flag_c_o
);
  sdiv_st_e         st_q;
  logic [DVD_W-1:0] dvd_q;
  logic [DVS_W-1:0] dvs_q;
  logic [REG_W-1:0] idx_q;
  logic [DVS_W-1:0] quot_q, rem_q;
  sdiv_flags_t      flags_q;
  logic             done_q, trap_q, wr_q;

  logic             is_trap, is_zero, is_maxneg, dvd_neg, dvs_neg;
  logic [DVD_W-1:0] dvd_mag, quo_mag;
  logic [DVS_W-1:0] dvs_mag, rem_mag, fx_quot, fx_rem;
  logic             load, step, last, ovf;
  sdiv_flags_t      fx_flags;

  sdiv_precheck #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_pre (
    .dvd_i(dvd_q), .dvs_i(dvs_q), .idx_odd_i(idx_q[0]),
    .is_trap_o(is_trap), .is_zero_o(is_zero), .is_maxneg_o(is_maxneg),
    .dvd_neg_o(dvd_neg), .dvs_neg_o(dvs_neg),
    .dvd_mag_o(dvd_mag), .dvs_mag_o(dvs_mag)
  );

  assign load = (st_q == ST_CHK) && !is_trap && !is_zero && !is_maxneg;
  assign step = (st_q == ST_DIV);

  sdiv_core #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_core (
    .clk_i, .rst_ni, .load_i(load), .step_i(step),
    .dvd_mag_i(dvd_mag), .dvs_mag_i(dvs_mag),
    .quo_mag_o(quo_mag), .rem_mag_o(rem_mag), .last_o(last)
  );

  sdiv_fixup #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_fix (
    .quo_mag_i(quo_mag), .rem_mag_i(rem_mag),
    .dvd_neg_i(dvd_neg), .dvs_neg_i(dvs_neg),
    .quot_o(fx_quot), .rem_o(fx_rem), .ovf_o(ovf), .flags_o(fx_flags)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      dvd_q   <= '0;
      dvs_q   <= '0;
      idx_q   <= '0;
      quot_q  <= '0;
      rem_q   <= '0;
      flags_q <= '0;
      done_q  <= 1'b0;
      trap_q  <= 1'b0;
      wr_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      trap_q <= 1'b0;
      wr_q   <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          dvd_q <= {dvd_hi_i, dvd_lo_i};
          dvs_q <= dvs_i;
          idx_q <= reg_idx_i;
          st_q  <= ST_CHK;
        end
        ST_CHK: begin
          // trap outranks both arithmetic special cases
          if (is_trap) begin
            trap_q <= 1'b1;
            done_q <= 1'b1;
            st_q   <= ST_IDLE;
          end else if (is_zero) begin
            flags_q <= '{n: 1'b0, z: 1'b1, v: 1'b1, c: 1'b1};
            done_q  <= 1'b1;
            st_q    <= ST_IDLE;
          end else if (is_maxneg) begin
            flags_q <= '{n: 1'b0, z: 1'b0, v: 1'b1, c: 1'b0};
            done_q  <= 1'b1;
            st_q    <= ST_IDLE;
          end else begin
            st_q <= ST_DIV;
          end
        end
        ST_DIV: if (last) st_q <= ST_FIX;
        ST_FIX: begin
          flags_q <= fx_flags;
          if (!ovf) begin
            quot_q <= fx_quot;
            rem_q  <= fx_rem;
            wr_q   <= 1'b1;
          end
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o    = (st_q != ST_IDLE);
  assign done_o    = done_q;
  assign trap_o    = trap_q;
  assign wr_even_o = wr_q;
  assign wr_odd_o  = wr_q;
  assign wb_base_o = {idx_q[REG_W-1:1], 1'b0};
  assign quot_o    = quot_q;
  assign rem_o     = rem_q;
  assign flag_n_o  = flags_q.n;
  assign flag_z_o  = flags_q.z;
  assign flag_v_o  = flags_q.v;
  assign flag_c_o  = flags_q.c;

  // R3
  trap_nowr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (!wr_even_o && !wr_odd_o && done_o));
  // R4
  dz_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && flag_z_o && flag_v_o) |-> (flag_c_o && !flag_n_o && !wr_even_o));
  // R6
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && flag_v_o) |-> (!wr_even_o && !wr_odd_o));
  // R7
  ok_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_even_o |-> (!flag_v_o && !flag_c_o && done_o));
  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  // R9
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> ($stable(dvd_q) && $stable(dvs_q)));
endmodule

// File: tb/sdiv32_unit_bench.sv
module sdiv32_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  idx = '0;
  logic [15:0] hi = '0, lo = '0, dvs = '0;
  logic        busy, done, trap, wr_e, wr_o, fn, fz, fv, fc;
  logic [2:0]  wb_base;
  logic [15:0] quot, rem;

  always #5 clk = ~clk;

  sdiv32_unit u_sdiv32_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .reg_idx_i(idx),
    .dvd_hi_i(hi), .dvd_lo_i(lo), .dvs_i(dvs),
    .busy_o(busy), .done_o(done), .trap_o(trap), .wb_base_o(wb_base),
    .wr_even_o(wr_e), .wr_odd_o(wr_o), .quot_o(quot), .rem_o(rem),
    .flag_n_o(fn), .flag_z_o(fz), .flag_v_o(fv), .flag_c_o(fc)
  );

  typedef struct {
    logic        trap;
    logic        wr;
    logic [15:0] q;
    logic [15:0] r;
    logic [3:0]  f;
    int          at;
    string       req;
  } exp_t;

  exp_t  sb[$];
  int    tests = 0, fails = 0, cyc = 0, seen = 0, issued = 0;
  logic [15:0] m_q = '0, m_r = '0;
  logic [3:0]  m_f = '0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // driver: model expected result, push it, pulse start
  task automatic run(input logic [2:0] i, input logic [31:0] d, input logic [15:0] s,
                     input string req, input bit poke_busy);
    exp_t e;
    longint sa, sb_v, q, r;
    int lat;
    sa   = longint'($signed(d));
    sb_v = longint'($signed(s));
    e.trap = 1'b0; e.wr = 1'b0; e.req = req;
    lat = 1;
    if (i[0]) begin
      e.trap = 1'b1;
    end else if (sb_v == 0) begin
      m_f = 4'b0111;
    end else if (d == 32'h8000_0000 && s == 16'hFFFF) begin
      m_f = 4'b0010;
    end else begin
      lat = 34;
      q = sa / sb_v;
      r = sa % sb_v;
      if (q > 32767 || q < -32768) begin
        m_f = {q < 0, 3'b010};
      end else begin
        m_f = {q < 0, q == 0, 2'b00};
        m_q = q[15:0];
        m_r = r[15:0];
        e.wr = 1'b1;
      end
    end
    e.q = m_q; e.r = m_r; e.f = m_f;
    @(negedge clk);
    e.at = cyc + 1 + lat;
    sb.push_back(e);
    issued++;
    start = 1'b1; idx = i; hi = d[31:16]; lo = d[15:0]; dvs = s;
    @(negedge clk);
    start = 1'b0;
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      // R9: second start while busy, different operands
      start = 1'b1; idx = 3'd4; hi = 16'h0000; lo = 16'h0064; dvs = 16'h0007;
      @(negedge clk);
      start = 1'b0;
    end
    wait (seen == issued);
    repeat (2) @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      exp_t e;
      seen++;
      if (sb.size() == 0) begin
        tests++; fails++;
        $display("FAIL R9 unexpected done: actual 1 expected 0");
      end else begin
        e = sb.pop_front();
        chk(e.req, "latency", cyc, e.at);
        chk(e.req, "trap", trap, e.trap);
        chk(e.req, "wr_even", wr_e, e.wr);
        chk(e.req, "wr_odd", wr_o, e.wr);
        chk(e.req, "quot", quot, e.q);
        chk(e.req, "rem", rem, e.r);
        chk(e.req, "flags", {fn, fz, fv, fc}, e.f);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk("R8", "reset busy", busy, 0);
    chk("R8", "reset done", done, 0);
    chk("R8", "reset outs", {trap, wr_e, quot, rem, fn, fz, fv, fc}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run(3'd0, 32'd7,          16'd2,      "R1", 0);
    run(3'd2, -32'sd7,        16'd2,      "R2", 0);
    run(3'd4, 32'd7,          -16'sd2,    "R1", 0);
    run(3'd6, -32'sd7,        -16'sd2,    "R2", 0);
    run(3'd0, 32'd0,          16'd5,      "R7", 0);
    run(3'd0, 32'd1000,       16'h8000,   "R7", 0);
    run(3'd2, 32'hFFFF_8000,  16'h8000,   "R1", 0);
    run(3'd0, 32'd98301,      16'd3,      "R1", 0);
    run(3'd0, -32'sd98304,    16'd3,      "R7", 0);
    run(3'd0, 32'd100000,     16'd3,      "R6", 0);
    run(3'd2, -32'sd100000,   16'd3,      "R6", 0);
    run(3'd0, 32'h7FFF_FFFF,  16'h7FFF,   "R6", 0);
    run(3'd4, 32'd1234,       16'd0,      "R4", 0);
    run(3'd0, 32'h8000_0000,  16'hFFFF,   "R5", 0);
    run(3'd3, 32'd50,         16'd5,      "R3", 0);
    run(3'd1, 32'd50,         16'd0,      "R3", 0);
    run(3'd6, -32'sd12345678, 16'd1000,   "R9", 1);
    run(3'd2, 32'd65535,      16'hFFFF,   "R8", 0);
    chk("R8", "idle busy", busy, 0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule